// File: doc/BRIEF.md
# Branch and loop condition resolver

This block decides, for one decoded control-transfer instruction per cycle, whether the transfer is taken, where the program counter goes next, and what the count register becomes. It serves the fetch stage of a small processor. The decoder supplies the branch kind, a condition selector, the flag vector, the count register and the sequential next-instruction address. It also supplies the instruction's displacement byte, its two absolute-address bytes and the raw opcode byte.

It resolves jumps on a single flag in either polarity, jump-if-count-zero, three counted loop forms that decrement the count register, unconditional absolute jumps and one-byte restart instructions. A restart instruction vectors to one of eight fixed low addresses. Results are registered and appear one cycle after the request. The block never writes any flag. Pushing a return address belongs to another unit.

Top module: `brc_resolver`

## Requirements
- R1: With `kind_i`=1 (flag jump), `cond_i[2:0]` selects a flag: index 0 carry, 1 zero, 2 sign, 3 overflow, 4 parity, and 5 to 7 read as 0. `cond_i[3]`=0 takes the branch when that flag is 1, and `cond_i[3]`=1 takes it when the flag is 0.
- R2: A taken short branch (kinds 1 to 5) goes to `seq_pc_i` plus `disp_i` read as a signed byte (-128..+127), modulo 2^ADDR_W.
- R3: With `kind_i`=3 (loop), the count is decremented. The branch is taken when the new count is nonzero and falls through when it is zero.
- R4: With `kind_i`=4 (loop while zero flag set), the count is decremented and the loop falls through when the new count is zero or flag 1 is 0.
- R5: With `kind_i`=5 (loop while zero flag clear), the count is decremented and the loop falls through when the new count is zero or flag 1 is 1.
- R6: The loop decrement wraps: a count of 0 becomes all ones, and the loop is taken.
- R7: With `kind_i`=2, the branch is taken exactly when `count_i` is zero, using the short target.
- R8: With `kind_i`=7, the jump is always taken to {`abs_hi_i`, `abs_lo_i`}, with the high byte taken from the third instruction byte.
- R9: With `kind_i`=6, an opcode of the form 11NNN111 is taken to address 00NNN000 (0x00, 0x08 .. 0x38). Any other opcode falls through.
- R10: A branch that is not taken yields `next_pc_o` = `seq_pc_i` and `taken_o`=0. `kind_i`=0 is never taken.
- R11: Results appear on the clock edge after a request with `valid_i`=1, and `valid_o` marks that cycle. Without a request, all outputs hold and `valid_o` is 0.
- R12: During reset, `next_pc_o`, `count_o`, `taken_o` and `valid_o` are 0.
- R13: Kinds other than 3, 4 and 5 return `count_i` unchanged on `count_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 3 | Branch kind code |
| cond_i | input | 4 | {negate, flag index} |
| flags_i | input | NFLAG | Flag vector |
| count_i | input | CNT_W | Count register value |
| seq_pc_i | input | ADDR_W | Sequential next-instruction address |
| disp_i | input | 8 | Signed short displacement |
| abs_lo_i | input | 8 | Second instruction byte (target low) |
| abs_hi_i | input | 8 | Third instruction byte (target high) |
| op_i | input | 8 | Raw opcode byte for restarts |
| next_pc_o | output | ADDR_W | Resolved next PC |
| count_o | output | CNT_W | Updated count register |
| taken_o | output | 1 | Transfer taken |
| valid_o | output | 1 | Result valid |

## Verification
The bench builds the block with its defaults: ADDR_W=16, CNT_W=16 and NFLAG=5. At these widths, short targets wrap past 0xFFFF and below 0x0000, and the count wrap from 0 to 0xFFFF is reached by single directed vectors. The default flag count leaves selector values 5 to 7 outside the flag vector, so their read-as-zero behaviour in both polarities is exercised. Directed corner vectors are followed by a long stream of random requests and idle cycles. That stream covers every kind, every condition code and every restart opcode pattern, against the bench's behavioural model.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    BK_SEQ    = 3'd0,
    BK_JFLAG  = 3'd1,
    BK_JCZ    = 3'd2,
    BK_LOOP   = 3'd3,
    BK_LOOPZ  = 3'd4,
    BK_LOOPNZ = 3'd5,
    BK_RST    = 3'd6,
    BK_JABS   = 3'd7
  } brk_kind_e;

  localparam int unsigned ZF_IDX  = 1;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned DISP_W  = 8;
  localparam int unsigned BYTE_W  = 8;

  function automatic logic is_loop(brk_kind_e k);
    return (k == BK_LOOP) || (k == BK_LOOPZ) || (k == BK_LOOPNZ);
  endfunction
endpackage

// File: rtl/brc_count_unit.sv
module brc_count_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] dec_o,
  output logic             zero_o,
  output logic             dec_zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign dec_o      = cnt_i - ONE;
  assign zero_o     = (cnt_i == '0);
  // new count is zero only when the old count was exactly one
  assign dec_zero_o = (cnt_i == ONE);
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int unsigned NFLAG = 5
) (
  input  brk_kind_e        kind_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             neg_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             cnt_zero_i,
  input  logic             dec_zero_i,
  input  logic             rst_ok_i,
  output logic             take_o
);
  logic flag_sel;
  logic zf;

  always_comb begin
    flag_sel = 1'b0;
    for (int i = 0; i < NFLAG; i++) begin
      if (sel_i == SEL_W'(i)) flag_sel = flags_i[i];
    end
  end

  assign zf = flags_i[ZF_IDX];

  always_comb begin
    unique case (kind_i)
      BK_SEQ:    take_o = 1'b0;
      BK_JFLAG:  take_o = flag_sel ^ neg_i;
      BK_JCZ:    take_o = cnt_zero_i;
      BK_LOOP:   take_o = !dec_zero_i;
      BK_LOOPZ:  take_o = !dec_zero_i && zf;
      BK_LOOPNZ: take_o = !dec_zero_i && !zf;
      BK_RST:    take_o = rst_ok_i;
      BK_JABS:   take_o = 1'b1;
      default:   take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen
  import brc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  brk_kind_e         kind_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [BYTE_W-1:0] abs_lo_i,
  input  logic [BYTE_W-1:0] abs_hi_i,
  input  logic [BYTE_W-1:0] op_i,
  output logic [ADDR_W-1:0] target_o,
  output logic              rst_ok_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] short_tgt;
  logic [ADDR_W-1:0] abs_tgt;
  logic [ADDR_W-1:0] rst_tgt;

  assign short_tgt = seq_pc_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  generate
    if (ADDR_W > 2 * BYTE_W) begin : g_abs_wide
      assign abs_tgt = {{(ADDR_W - 2 * BYTE_W){1'b0}}, abs_hi_i, abs_lo_i};
    end else begin : g_abs_exact
      assign abs_tgt = {abs_hi_i, abs_lo_i};
    end
  endgenerate

  assign rst_ok_o = (op_i[7:6] == 2'b11) && (op_i[2:0] == 3'b111);
  assign rst_tgt  = ADDR_W'({op_i[5:3], 3'b000});

  always_comb begin
    unique case (kind_i)
      BK_JABS: target_o = abs_tgt;
      BK_RST:  target_o = rst_tgt;
      default: target_o = short_tgt;
    endcase
  end
endmodule

// File: rtl/brc_resolver.sv
module brc_resolver
  import brc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NFLAG  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic [7:0]        disp_i,
  input  logic [7:0]        abs_lo_i,
  input  logic [7:0]        abs_hi_i,
  input  logic [7:0]        op_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              taken_o,
  output logic              valid_o
);
  brk_kind_e         kind;
  logic [CNT_W-1:0]  cnt_dec;
  logic              cnt_zero;
  logic              dec_zero;
  logic              rst_ok;
  logic              take;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pc_d;
  logic [CNT_W-1:0]  cnt_d;

  assign kind = brk_kind_e'(kind_i);

  brc_count_unit #(.CNT_W(CNT_W)) i_cnt (
    .cnt_i      (count_i),
    .dec_o      (cnt_dec),
    .zero_o     (cnt_zero),
    .dec_zero_o (dec_zero)
  );

  brc_target_gen #(.ADDR_W(ADDR_W)) i_tgt (
    .kind_i   (kind),
    .seq_pc_i (seq_pc_i),
    .disp_i   (disp_i),
    .abs_lo_i (abs_lo_i),
    .abs_hi_i (abs_hi_i),
    .op_i     (op_i),
    .target_o (target),
    .rst_ok_o (rst_ok)
  );

  brc_cond_eval #(.NFLAG(NFLAG)) i_cond (
    .kind_i     (kind),
    .sel_i      (cond_i[SEL_W-1:0]),
    .neg_i      (cond_i[3]),
    .flags_i    (flags_i),
    .cnt_zero_i (cnt_zero),
    .dec_zero_i (dec_zero),
    .rst_ok_i   (rst_ok),
    .take_o     (take)
  );

  assign pc_d  = take ? target : seq_pc_i;
  assign cnt_d = is_loop(kind) ? cnt_dec : count_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      count_o   <= '0;
      taken_o   <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        next_pc_o <= pc_d;
        count_o   <= cnt_d;
        taken_o   <= take;
      end
    end
  end
endmodule

// File: rtl/brc_resolver_chk.sv
module brc_resolver_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NFLAG  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        kind_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [ADDR_W-1:0] seq_pc_i,
  input logic [7:0]        abs_lo_i,
  input logic [7:0]        abs_hi_i,
  input logic [7:0]        op_i,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              taken_o,
  input logic              valid_o
);
  logic is_lp;
  assign is_lp = (kind_i == 3'd3) || (kind_i == 3'd4) || (kind_i == 3'd5);

  p_valid_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(next_pc_o) && $stable(count_o) && $stable(taken_o));

  p_seq_fallthru_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd0 |=> !taken_o && next_pc_o == $past(seq_pc_i));

  p_abs_jump_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd7 |=>
      taken_o && next_pc_o == ADDR_W'({$past(abs_hi_i), $past(abs_lo_i)}));

  p_rst_vector_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd6 && op_i[7:6] == 2'b11 && op_i[2:0] == 3'b111 |=>
      taken_o && next_pc_o[2:0] == 3'b000 && next_pc_o[5:3] == $past(op_i[5:3])
      && (next_pc_o >> 6) == '0);

  p_rst_bad_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd6 && !(op_i[7:6] == 2'b11 && op_i[2:0] == 3'b111) |=>
      !taken_o && next_pc_o == $past(seq_pc_i));

  p_loop_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_lp |=> count_o == $past(count_i) - CNT_W'(1));

  p_count_keep_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_lp |=> count_o == $past(count_i));

  p_loop_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_lp && count_i == CNT_W'(1) |=> !taken_o);

  p_jcz_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd2 && count_i != '0 |=> !taken_o && next_pc_o == $past(seq_pc_i));
endmodule

bind brc_resolver brc_resolver_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NFLAG(NFLAG)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .kind_i    (kind_i),
  .count_i   (count_i),
  .seq_pc_i  (seq_pc_i),
  .abs_lo_i  (abs_lo_i),
  .abs_hi_i  (abs_hi_i),
  .op_i      (op_i),
  .next_pc_o (next_pc_o),
  .count_o   (count_o),
  .taken_o   (taken_o),
  .valid_o   (valid_o)
);

// File: tb/test_brc_resolver.sv
module test_brc_resolver;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int NFLAG  = 5;
  localparam int AMOD   = 1 << ADDR_W;
  localparam int CMOD   = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid;
  logic [2:0]        kind;
  logic [3:0]        cond;
  logic [NFLAG-1:0]  flags;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] seq_pc;
  logic [7:0]        disp, abs_lo, abs_hi, op;
  logic [ADDR_W-1:0] next_pc;
  logic [CNT_W-1:0]  count_out;
  logic              taken, valid_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int    e_pc = 0, e_cnt = 0, e_tak = 0, e_vld = 0;
  string e_tag = "R12";

  always #4 clk = ~clk;

  brc_resolver #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NFLAG(NFLAG)) i_brc_resolver (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .kind_i(kind), .cond_i(cond),
    .flags_i(flags), .count_i(count), .seq_pc_i(seq_pc), .disp_i(disp),
    .abs_lo_i(abs_lo), .abs_hi_i(abs_hi), .op_i(op),
    .next_pc_o(next_pc), .count_o(count_out), .taken_o(taken), .valid_o(valid_out)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pc = 0; e_cnt = 0; e_tak = 0; e_vld = 0; e_tag = "R12";
    end else if (!valid) begin
      e_vld = 0; e_tag = "R11";
    end else begin
      int s, c, d, raw, nc, tgt, tk, fv, sel;
      s = int'(seq_pc); c = int'(count);
      d = (disp >= 8'd128) ? int'(disp) - 256 : int'(disp);
      raw = s + d;
      tgt = (raw + AMOD) % AMOD;
      nc = (c + CMOD - 1) % CMOD;
      e_cnt = c;
      case (kind)
        3'd0: begin tk = 0; e_tag = "R10"; end
        3'd1: begin
          sel = int'(cond[2:0]);
          fv = (sel < NFLAG) ? int'(flags[sel]) : 0;
          tk = (cond[3] ? (fv == 0) : (fv == 1)) ? 1 : 0;
          e_tag = (raw < 0 || raw >= AMOD) ? "R2" : "R1";
        end
        3'd2: begin tk = (c == 0) ? 1 : 0; e_tag = "R7"; end
        3'd3: begin tk = (nc != 0) ? 1 : 0; e_cnt = nc; e_tag = (c == 0) ? "R6" : "R3"; end
        3'd4: begin tk = (nc != 0 && flags[1]) ? 1 : 0; e_cnt = nc; e_tag = "R4"; end
        3'd5: begin tk = (nc != 0 && !flags[1]) ? 1 : 0; e_cnt = nc; e_tag = "R5"; end
        3'd6: begin
          tk = (op[7:6] == 2'b11 && op[2:0] == 3'b111) ? 1 : 0;
          tgt = int'(op[5:3]) * 8; e_tag = "R9";
        end
        default: begin tk = 1; tgt = int'(abs_hi) * 256 + int'(abs_lo); e_tag = "R8,R13"; end
      endcase
      e_pc = tk ? tgt : s;
      e_tak = tk;
      e_vld = 1;
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (int'(next_pc) != e_pc || int'(count_out) != e_cnt ||
        int'(taken) != e_tak || int'(valid_out) != e_vld) begin
      n_bad++;
      $display("FAIL %s: pc=%h cnt=%h tak=%0d vld=%0d expected pc=%h cnt=%h tak=%0d vld=%0d",
               e_tag, next_pc, count_out, taken, valid_out, e_pc, e_cnt, e_tak, e_vld);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R11: watchdog expired at cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic req(input logic v, input logic [2:0] k, input logic [3:0] cd,
                     input logic [NFLAG-1:0] f, input logic [CNT_W-1:0] cn,
                     input logic [ADDR_W-1:0] pc, input logic [7:0] dp,
                     input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] o);
    @(negedge clk);
    valid = v; kind = k; cond = cd; flags = f; count = cn; seq_pc = pc;
    disp = dp; abs_lo = lo; abs_hi = hi; op = o;
  endtask

  initial begin
    valid = 0; kind = 0; cond = 0; flags = 0; count = 0; seq_pc = 0;
    disp = 0; abs_lo = 0; abs_hi = 0; op = 0;
    repeat (3) @(negedge clk);  // R12 reset state compared here
    rst_n = 1'b1;
    // R10 sequential
    req(1, 3'd0, 4'h0, 5'h1f, 16'h0042, 16'h1234, 8'h10, 8'h00, 8'h00, 8'h00);
    // R1 flag jumps, both polarities, out-of-range selector
    req(1, 3'd1, 4'h0, 5'b00001, 16'h0, 16'h1000, 8'h10, 0, 0, 0);
    req(1, 3'd1, 4'h8, 5'b00001, 16'h0, 16'h1000, 8'h10, 0, 0, 0);
    req(1, 3'd1, 4'h4, 5'b00000, 16'h0, 16'h2000, 8'hF0, 0, 0, 0);
    req(1, 3'd1, 4'hC, 5'b00000, 16'h0, 16'h2000, 8'hF0, 0, 0, 0);
    req(1, 3'd1, 4'h6, 5'b11111, 16'h0, 16'h3000, 8'h05, 0, 0, 0);
    req(1, 3'd1, 4'hE, 5'b11111, 16'h0, 16'h3000, 8'h05, 0, 0, 0);
    // R2 extremes and wraps
    req(1, 3'd1, 4'h1, 5'b00010, 16'h0, 16'h0010, 8'h80, 0, 0, 0);
    req(1, 3'd1, 4'h1, 5'b00010, 16'h0, 16'hFFF0, 8'h7F, 0, 0, 0);
    // R11 idle hold
    req(0, 3'd7, 4'h0, 5'h0, 16'h5555, 16'hAAAA, 8'h00, 8'h12, 8'h34, 0);
    req(0, 3'd3, 4'h0, 5'h0, 16'h5555, 16'hAAAA, 8'h00, 8'h12, 8'h34, 0);
    // R3 R4 R5 R6 loops
    req(1, 3'd3, 4'h0, 5'h0, 16'h0001, 16'h0400, 8'hFC, 0, 0, 0);
    req(1, 3'd3, 4'h0, 5'h0, 16'h0005, 16'h0400, 8'hFC, 0, 0, 0);
    req(1, 3'd3, 4'h0, 5'h0, 16'h0000, 16'h0400, 8'hFC, 0, 0, 0);
    req(1, 3'd4, 4'h0, 5'b00010, 16'h0003, 16'h0500, 8'hF8, 0, 0, 0);
    req(1, 3'd4, 4'h0, 5'b00000, 16'h0003, 16'h0500, 8'hF8, 0, 0, 0);
    req(1, 3'd5, 4'h0, 5'b00000, 16'h0003, 16'h0600, 8'hF8, 0, 0, 0);
    req(1, 3'd5, 4'h0, 5'b00010, 16'h0003, 16'h0600, 8'hF8, 0, 0, 0);
    req(1, 3'd5, 4'h0, 5'b00000, 16'h0001, 16'h0600, 8'hF8, 0, 0, 0);
    // R7 count-zero jump
    req(1, 3'd2, 4'h0, 5'h0, 16'h0000, 16'h0700, 8'h20, 0, 0, 0);
    req(1, 3'd2, 4'h0, 5'h0, 16'h0100, 16'h0700, 8'h20, 0, 0, 0);
    // R8 R13 absolute
    req(1, 3'd7, 4'h0, 5'h0, 16'hBEEF, 16'h0800, 8'h00, 8'h34, 8'h12, 0);
    // R9 restarts, all vectors plus malformed
    for (int n = 0; n < 8; n++)
      req(1, 3'd6, 4'h0, 5'h0, 16'h0009, 16'h0900, 8'h00, 0, 0, 8'hC7 | 8'(n << 3));
    req(1, 3'd6, 4'h0, 5'h0, 16'h0009, 16'h0900, 8'h00, 0, 0, 8'hC6);
    req(1, 3'd6, 4'h0, 5'h0, 16'h0009, 16'h0900, 8'h00, 0, 0, 8'h87);
    // random stream
    for (int i = 0; i < 3000; i++)
      req(($urandom % 4) != 0, 3'($urandom), 4'($urandom), 5'($urandom),
          (($urandom % 4) == 0) ? 16'($urandom % 3) : 16'($urandom),
          16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    req(0, 3'd0, 4'h0, 5'h0, 16'h0, 16'h0, 8'h0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule